// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block is the coherence controller of one cache in a shared-bus multiprocessor. Each line of a small direct-mapped array is in one of four states: Invalid, Valid (clean, possibly also held elsewhere), Reserved (written once, memory current, held only here) or Dirty (modified, held only here). The first store to a clean line goes through to memory as a single-word write. That write also removes every other copy. Later stores stay in the cache. Lines are one word wide.

The processor side takes one load or store at a time. The cache answers with a one-cycle ready pulse. The bus side issues requests and waits for a grant. It can issue a shared read, a read-for-ownership, a one-word write-through or a write-back. A read returns its data with an acknowledge. The snoop side watches transactions from other masters. It raises an inhibit output in the same cycle as a snooped address when this cache holds that block Dirty. In that same cycle it drives the line onto a supply bus, so that memory and the requester take the data from this cache.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_ready` and `snp_inh` are low, and a snooped read inhibits nothing.
- R2: A load miss issues a bus read (`bus_cmd` = 1) at the load address. The command and address are held until `bus_gnt`. The word returned with `bus_ack` is given to the processor, and the line becomes Valid.
- R3: A store hitting a Valid line issues a write-through (`bus_cmd` = 3) carrying the address and the store word, and the line becomes Reserved.
- R4: A store hitting a Reserved line completes one cycle after the request with no bus request, and the line becomes Dirty.
- R5: A store hitting a Dirty line completes one cycle after the request with no bus request, and the line stays Dirty with the new word.
- R6: A store miss issues a read-for-ownership (`bus_cmd` = 2), and the line becomes Dirty holding the store word.
- R7: A snooped read (`snp_cmd` = 1) to a Reserved line moves it to Valid without inhibit, so the next local store writes through again.
- R8: A snooped read to a Dirty line raises `snp_inh` in the same cycle, drives the line word on `snp_data`, and leaves the line Valid.
- R9: A snooped read-for-ownership (2) or write-through (3) to a held line invalidates it, so the next load misses. A Dirty line raises `snp_inh` and supplies its word first.
- R10: A miss whose victim is Dirty first issues a write-back (`bus_cmd` = 4) of the victim address and word, then the fill. A Valid or Reserved victim is dropped with no bus traffic.
- R11: A load hit returns the word one cycle after the request with no bus request. `cpu_ready` is a single-cycle pulse.
- R12: A snoop to a block not held, or a snooped write-back (4), changes nothing and raises no inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store word |
| cpu_ready | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transaction occurs in the granted cycle |
| bus_cmd | output | 3 | 1 read, 2 read-for-ownership, 3 write-through, 4 write-back |
| bus_addr | output | ADDR_W | Request address |
| bus_wdata | output | DATA_W | Word for write-through or write-back |
| bus_ack | input | 1 | Read data valid |
| bus_rdata | input | DATA_W | Read data |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_inh | output | 1 | Memory inhibit, same cycle as the snoop |
| snp_data | output | DATA_W | Line word supplied while inhibiting |

## Verification
The bench uses an 8-bit address, 16-bit words and four lines (IDX_W = 2). With only four lines, addresses 0x10, 0x30, 0x50 and 0x70 share line 0, so silent eviction, write-back eviction and snoops to blocks that are not held all arise with a handful of addresses. Narrow words keep every written value distinct, so data supplied under inhibit can be told apart from stale memory contents.

// File: rtl/wo_pkg.sv
package wo_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_V = 2'd1,
        ST_R = 2'd2,
        ST_D = 2'd3
    } wo_state_e;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_RD    = 3'd1,
        CMD_RDX   = 3'd2,
        CMD_WONCE = 3'd3,
        CMD_WB    = 3'd4
    } wo_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE = 3'd0,
        F_WT   = 3'd1,
        F_EV   = 3'd2,
        F_FILL = 3'd3,
        F_WAIT = 3'd4
    } wo_fsm_e;

endpackage

// File: rtl/wo_line_array.sv
module wo_line_array
    import wo_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  wo_state_e         wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output wo_state_e         ra_st,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output wo_state_e         rb_st,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        wo_state_e         st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t lines_q [LINES];
    line_t lines_d [LINES];

    always_comb begin
        lines_d = lines_q;
        if (wr_en) begin
            lines_d[wr_idx].st   = wr_st;
            lines_d[wr_idx].tag  = wr_tag;
            lines_d[wr_idx].data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                lines_q[i].st   <= ST_I;
                lines_q[i].tag  <= '0;
                lines_q[i].data <= '0;
            end
        end else begin
            lines_q <= lines_d;
        end
    end

    assign ra_st   = lines_q[ra_idx].st;
    assign ra_tag  = lines_q[ra_idx].tag;
    assign ra_data = lines_q[ra_idx].data;
    assign rb_st   = lines_q[rb_idx].st;
    assign rb_tag  = lines_q[rb_idx].tag;
    assign rb_data = lines_q[rb_idx].data;

endmodule

// File: rtl/wo_snoop_resp.sv
module wo_snoop_resp
    import wo_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  wo_cmd_e           snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  wo_state_e         line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd,
    output wo_state_e         upd_st,
    output logic              inh,
    output logic [DATA_W-1:0] sup_data
);
    logic hit;

    always_comb begin
        hit      = (line_st != ST_I) && (line_tag == snp_tag);
        upd      = 1'b0;
        upd_st   = line_st;
        inh      = 1'b0;
        sup_data = line_data;
        if (snp_valid && hit) begin
            unique case (snp_cmd)
                CMD_RD: begin
                    if (line_st == ST_R || line_st == ST_D) begin
                        upd    = 1'b1;
                        upd_st = ST_V;
                    end
                    inh = (line_st == ST_D);
                end
                CMD_RDX, CMD_WONCE: begin
                    upd    = 1'b1;
                    upd_st = ST_I;
                    inh    = (line_st == ST_D);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wo_fsm.sv
module wo_fsm
    import wo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              stall,
    output logic [IDX_W-1:0]  rd_idx,
    input  wo_state_e         line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output wo_state_e         wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output wo_cmd_e           bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        wo_fsm_e           st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic              hit;

    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b0;
        cur_addr  = (r_q.st == F_IDLE) ? cpu_addr : r_q.addr;
        cur_tag   = cur_addr[ADDR_W-1:IDX_W];
        rd_idx    = cur_addr[IDX_W-1:0];
        hit       = (line_st != ST_I) && (line_tag == cur_tag);
        wr_en     = 1'b0;
        wr_idx    = rd_idx;
        wr_st     = ST_I;
        wr_tag    = cur_tag;
        wr_data   = r_q.wdata;
        bus_req   = 1'b0;
        bus_cmd   = CMD_NONE;
        bus_addr  = r_q.addr;
        bus_wdata = r_q.wdata;

        unique case (r_q.st)
            F_IDLE: begin
                if (cpu_req && !r_q.ready && !stall) begin
                    r_d.we    = cpu_we;
                    r_d.addr  = cpu_addr;
                    r_d.wdata = cpu_wdata;
                    if (hit && !cpu_we) begin
                        r_d.ready = 1'b1;
                        r_d.rdata = line_data;
                    end else if (hit && (line_st == ST_R || line_st == ST_D)) begin
                        wr_en     = 1'b1;
                        wr_st     = ST_D;
                        wr_data   = cpu_wdata;
                        r_d.ready = 1'b1;
                    end else if (hit) begin
                        r_d.st = F_WT;
                    end else if (line_st == ST_D) begin
                        r_d.st = F_EV;
                    end else begin
                        r_d.st = F_FILL;
                    end
                end
            end
            F_WT: begin
                if (hit && line_st == ST_V) begin
                    bus_req = 1'b1;
                    bus_cmd = CMD_WONCE;
                    if (bus_gnt) begin
                        wr_en     = 1'b1;
                        wr_st     = ST_R;
                        r_d.ready = 1'b1;
                        r_d.st    = F_IDLE;
                    end
                end else begin
                    r_d.st = F_FILL;
                end
            end
            F_EV: begin
                if (line_st == ST_D) begin
                    bus_req   = 1'b1;
                    bus_cmd   = CMD_WB;
                    bus_addr  = {line_tag, rd_idx};
                    bus_wdata = line_data;
                    if (bus_gnt) r_d.st = F_FILL;
                end else begin
                    r_d.st = F_FILL;
                end
            end
            F_FILL: begin
                bus_req = 1'b1;
                bus_cmd = r_q.we ? CMD_RDX : CMD_RD;
                if (bus_gnt) r_d.st = F_WAIT;
            end
            F_WAIT: begin
                if (bus_ack) begin
                    wr_en     = 1'b1;
                    wr_st     = r_q.we ? ST_D : ST_V;
                    wr_data   = r_q.we ? r_q.wdata : bus_rdata;
                    r_d.rdata = bus_rdata;
                    r_d.ready = 1'b1;
                    r_d.st    = F_IDLE;
                end
            end
            default: r_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: F_IDLE, we: 1'b0, addr: '0, wdata: '0, ready: 1'b0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ready = r_q.ready;
    assign cpu_rdata = r_q.rdata;

    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r3_wonce_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == CMD_WONCE) |=> (cpu_ready && !bus_req));

    a_r2_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == F_WAIT && bus_ack) |=> cpu_ready);

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !stall) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    a_r10_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == CMD_WB) |=>
            (bus_req && (bus_cmd == CMD_RD || bus_cmd == CMD_RDX)));

endmodule

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl
    import wo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_inh,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    wo_cmd_e           snp_cmd_e, fsm_cmd;
    logic [IDX_W-1:0]  snp_idx, fsm_rd_idx, fsm_wr_idx, arr_wr_idx;
    logic [TAG_W-1:0]  snp_tag;
    wo_state_e         a_st, b_st, fsm_wr_st, snp_upd_st, arr_wr_st;
    logic [TAG_W-1:0]  a_tag, b_tag, fsm_wr_tag, arr_wr_tag;
    logic [DATA_W-1:0] a_data, b_data, fsm_wr_data, arr_wr_data;
    logic              fsm_wr_en, snp_upd, arr_wr_en;

    assign snp_cmd_e = wo_cmd_e'(snp_cmd);
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[ADDR_W-1:IDX_W];

    // Snoop updates win the single write port; the FSM stalls while snooping.
    assign arr_wr_en   = snp_upd | fsm_wr_en;
    assign arr_wr_idx  = snp_upd ? snp_idx    : fsm_wr_idx;
    assign arr_wr_st   = snp_upd ? snp_upd_st : fsm_wr_st;
    assign arr_wr_tag  = snp_upd ? b_tag      : fsm_wr_tag;
    assign arr_wr_data = snp_upd ? b_data     : fsm_wr_data;
    assign bus_cmd     = fsm_cmd;

    wo_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (arr_wr_en),
        .wr_idx  (arr_wr_idx),
        .wr_st   (arr_wr_st),
        .wr_tag  (arr_wr_tag),
        .wr_data (arr_wr_data),
        .ra_idx  (fsm_rd_idx),
        .ra_st   (a_st),
        .ra_tag  (a_tag),
        .ra_data (a_data),
        .rb_idx  (snp_idx),
        .rb_st   (b_st),
        .rb_tag  (b_tag),
        .rb_data (b_data)
    );

    wo_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd_e),
        .snp_tag   (snp_tag),
        .line_st   (b_st),
        .line_tag  (b_tag),
        .line_data (b_data),
        .upd       (snp_upd),
        .upd_st    (snp_upd_st),
        .inh       (snp_inh),
        .sup_data  (snp_data)
    );

    wo_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .stall     (snp_valid),
        .rd_idx    (fsm_rd_idx),
        .line_st   (a_st),
        .line_tag  (a_tag),
        .line_data (a_data),
        .wr_en     (fsm_wr_en),
        .wr_idx    (fsm_wr_idx),
        .wr_st     (fsm_wr_st),
        .wr_tag    (fsm_wr_tag),
        .wr_data   (fsm_wr_data),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_cmd   (fsm_cmd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    // R8/R9: once a dirty owner has supplied the block it no longer owns it.
    a_r8_inh_once: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_inh) |=>
            !(snp_valid && snp_inh && $stable(snp_addr) && $stable(snp_cmd)));

    a_r12_wb_snoop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 3'd4) |-> !snp_inh);

endmodule

// File: tb/tb_wo_coherence_ctrl.sv
module tb_wo_coherence_ctrl;
    import wo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 2;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic bus_req;
    logic bus_gnt = 1'b0;
    logic [2:0] bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic bus_ack = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic snp_valid = 1'b0;
    logic [2:0] snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic snp_inh;
    logic [DATA_W-1:0] snp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    wo_coherence_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_inh(snp_inh), .snp_data(snp_data)
    );

    typedef struct {
        logic [2:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        string             req;
    } bus_item_t;

    bus_item_t exp_q[$];
    logic [DATA_W-1:0] mem [1 << ADDR_W];
    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_bus(input wo_cmd_e c, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] d, input string req);
        bus_item_t it;
        it.cmd = c; it.addr = a; it.data = d; it.req = req;
        exp_q.push_back(it);
    endtask

    // Bus monitor: grants every request, compares it against the scoreboard, models memory.
    initial begin
        bus_item_t e;
        logic [2:0] c_s;
        logic [ADDR_W-1:0] a_s;
        logic [DATA_W-1:0] d_s;
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (rst_n && bus_req) begin
                c_s = bus_cmd; a_s = bus_addr; d_s = bus_wdata;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "BUS", "unexpected request cmd", 32'(c_s), 32'(0));
                end else begin
                    e = exp_q.pop_front();
                    chk(c_s == e.cmd, e.req, "bus cmd", 32'(c_s), 32'(e.cmd));
                    chk(a_s == e.addr, e.req, "bus addr", 32'(a_s), 32'(e.addr));
                    if (e.cmd == CMD_WONCE || e.cmd == CMD_WB)
                        chk(d_s == e.data, e.req, "bus wdata", 32'(d_s), 32'(e.data));
                end
                bus_gnt = 1'b1;
                @(negedge clk);
                bus_gnt = 1'b0;
                if (c_s == CMD_RD || c_s == CMD_RDX) begin
                    bus_rdata = mem[a_s];
                    bus_ack = 1'b1;
                end else begin
                    mem[a_s] = d_s;
                end
            end
        end
    end

    task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          input logic [DATA_W-1:0] exp_rd, input int exp_lat, input string req);
        int lat;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 100);
        chk(cpu_ready, req, "cpu ready", 32'(cpu_ready), 32'(1));
        if (!we) chk(cpu_rdata == exp_rd, req, "load data", 32'(cpu_rdata), 32'(exp_rd));
        if (exp_lat > 0) chk(lat == exp_lat, req, "latency", 32'(lat), 32'(exp_lat));
        chk(exp_q.size() == 0, req, "pending bus items", 32'(exp_q.size()), 32'(0));
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input wo_cmd_e c, input logic [ADDR_W-1:0] a, input bit exp_inh,
                         input logic [DATA_W-1:0] d, input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        chk(snp_inh == exp_inh, req, "inhibit", 32'(snp_inh), 32'(exp_inh));
        if (exp_inh) begin
            chk(snp_data == d, req, "supplied data", 32'(snp_data), 32'(d));
            mem[a] = snp_data;
        end else if (c == CMD_WONCE) begin
            mem[a] = d;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = DATA_W'(16'h1000 + i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b0, "R1", "bus_req after reset", 32'(bus_req), 32'(0));
        chk(cpu_ready == 1'b0, "R1", "cpu_ready after reset", 32'(cpu_ready), 32'(0));
        chk(snp_inh == 1'b0, "R1", "inhibit after reset", 32'(snp_inh), 32'(0));
        snoop(CMD_RD, 8'h10, 1'b0, '0, "R1");

        // Load miss then hit
        expect_bus(CMD_RD, 8'h10, '0, "R2");
        cpu_op(1'b0, 8'h10, '0, 16'h1010, 0, "R2");
        cpu_op(1'b0, 8'h10, '0, 16'h1010, 1, "R11");

        // First store writes through, second stays local
        expect_bus(CMD_WONCE, 8'h10, 16'hA001, "R3");
        cpu_op(1'b1, 8'h10, 16'hA001, '0, 0, "R3");
        cpu_op(1'b0, 8'h10, '0, 16'hA001, 1, "R3");
        cpu_op(1'b1, 8'h10, 16'hA002, '0, 1, "R4");
        snoop(CMD_RD, 8'h10, 1'b1, 16'hA002, "R8");
        expect_bus(CMD_WONCE, 8'h10, 16'hA003, "R8");
        cpu_op(1'b1, 8'h10, 16'hA003, '0, 0, "R8");

        // Snooped read on Reserved
        snoop(CMD_RD, 8'h10, 1'b0, '0, "R7");
        expect_bus(CMD_WONCE, 8'h10, 16'hA004, "R7");
        cpu_op(1'b1, 8'h10, 16'hA004, '0, 0, "R7");

        // Dirty hits
        cpu_op(1'b1, 8'h10, 16'hA005, '0, 1, "R4");
        cpu_op(1'b1, 8'h10, 16'hA006, '0, 1, "R5");
        cpu_op(1'b0, 8'h10, '0, 16'hA006, 1, "R5");
        snoop(CMD_RD, 8'h10, 1'b1, 16'hA006, "R5");

        // Store miss and remote ownership
        expect_bus(CMD_RDX, 8'h21, '0, "R6");
        cpu_op(1'b1, 8'h21, 16'hB001, '0, 0, "R6");
        cpu_op(1'b0, 8'h21, '0, 16'hB001, 1, "R6");
        snoop(CMD_RDX, 8'h21, 1'b1, 16'hB001, "R9");
        expect_bus(CMD_RD, 8'h21, '0, "R9");
        cpu_op(1'b0, 8'h21, '0, 16'hB001, 0, "R9");
        snoop(CMD_WONCE, 8'h21, 1'b0, 16'hC0DE, "R9");
        expect_bus(CMD_RD, 8'h21, '0, "R9");
        cpu_op(1'b0, 8'h21, '0, 16'hC0DE, 0, "R9");
        expect_bus(CMD_WONCE, 8'h10, 16'hA007, "R9");
        cpu_op(1'b1, 8'h10, 16'hA007, '0, 0, "R9");
        snoop(CMD_RDX, 8'h10, 1'b0, '0, "R9");
        expect_bus(CMD_RD, 8'h10, '0, "R9");
        cpu_op(1'b0, 8'h10, '0, 16'hA007, 0, "R9");

        // Eviction: silent for Valid, write-back for Dirty
        expect_bus(CMD_RD, 8'h30, '0, "R10");
        cpu_op(1'b0, 8'h30, '0, 16'h1030, 0, "R10");
        expect_bus(CMD_WONCE, 8'h30, 16'hD001, "R10");
        cpu_op(1'b1, 8'h30, 16'hD001, '0, 0, "R10");
        cpu_op(1'b1, 8'h30, 16'hD002, '0, 1, "R10");
        expect_bus(CMD_WB, 8'h30, 16'hD002, "R10");
        expect_bus(CMD_RDX, 8'h50, '0, "R10");
        cpu_op(1'b1, 8'h50, 16'hE001, '0, 0, "R10");
        cpu_op(1'b0, 8'h50, '0, 16'hE001, 1, "R10");
        chk(mem[8'h30] == 16'hD002, "R10", "memory after write-back", 32'(mem[8'h30]), 32'(16'hD002));

        // Snoops with no effect
        snoop(CMD_RD, 8'h70, 1'b0, '0, "R12");
        snoop(CMD_RDX, 8'h70, 1'b0, '0, "R12");
        snoop(CMD_WB, 8'h50, 1'b0, '0, "R12");
        cpu_op(1'b0, 8'h50, '0, 16'hE001, 1, "R12");
        snoop(CMD_RD, 8'h50, 1'b1, 16'hE001, "R12");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "BUS", "leftover bus items", 32'(exp_q.size()), 32'(0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule